// File: doc/BRIEF.md
# Configurable Status Output Port

This block drives three general-purpose status pins of a communication controller. Each pin picks its signal from one of three source groups. The protocol group carries the status flags produced elsewhere in the controller. The timing group is fed by a built-in time counter and by the core clock. The guard group carries the transmit-gate enables and the action-time pulse. Each pin also has its own drive style: it can drive both levels (push-pull), or it can only pull low and otherwise release the line (open-drain). An external pull resistor then sets the released level.

The built-in time counter advances by one on every cycle in which `tick_en` is high, so a prescaler can sit outside the block. It gives a one-cycle tick pulse on every advance and a one-cycle wrap pulse when it rolls over. After reset every output enable is low, and the pins stay that way until a single-cycle init strobe loads the configuration. That configuration is then frozen until the next reset.

Top module: `status_port_top`

## Requirements
- R1: From reset until the first `init_stb` cycle, `pin_oe` is 3'b000 and `pin_o` is 3'b000, whatever the other inputs do.
- R2: The configuration inputs are captured at the clock edge where `init_stb` is high for the first time after reset. Later strobes have no effect on the outputs until the next reset.
- R3: Pin i takes its source group from `cfg_mode[2i+1:2i]`: 00 is protocol, 01 is timing, 10 is guard, and 11 releases the pin (`pin_oe[i]`=0, `pin_o[i]`=0).
- R4: In protocol mode with `cfg_swap`=0, pin 2 shows `st_vote`, pin 1 shows `st_sync_ok` and pin 0 shows `st_active`.
- R5: With `cfg_swap`=1, protocol-mode pin 2 shows `st_active` and pin 0 shows `st_vote`. The swap has no effect on timing or guard mode.
- R6: In timing mode, pin 1 is high for exactly the one cycle after each clock edge at which `tick_en` was high, and is low otherwise.
- R7: In timing mode, pin 2 is high for one cycle after the 2^CNT_W-th accepted tick since reset (the counter wraps from all ones to zero), and is low otherwise.
- R8: In timing mode, pin 0 follows the core clock: high while `clk` is high and low while it is low.
- R9: In guard mode, pin 2 shows `bg_act`, pin 1 shows `bg_gate1` and pin 0 shows `bg_gate0`.
- R10: A configured, non-released pin with `cfg_od[i]`=0 has `pin_oe[i]`=1 and `pin_o[i]` equal to its selected source.
- R11: A pin with `cfg_od[i]`=1 has `pin_o[i]`=0, and `pin_oe[i]` is the inverse of its selected source.
- R12: Source group and drive style are applied per pin, so pins with different settings behave independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; also the timing-mode source of pin 0 |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Advances the time counter by one when high |
| init_stb | input | 1 | Single-cycle strobe that captures the configuration |
| cfg_mode | input | 6 | Two source-group bits per pin, pin i at [2i+1:2i] |
| cfg_od | input | 3 | Drive style per pin, 1 = open-drain |
| cfg_swap | input | 1 | Exchanges the pin 2 and pin 0 protocol sources |
| st_vote | input | 1 | Protocol flag: remote vote |
| st_sync_ok | input | 1 | Protocol flag: synchronisation valid |
| st_active | input | 1 | Protocol flag: protocol activity |
| bg_act | input | 1 | Guard action-time pulse |
| bg_gate1 | input | 1 | Guard transmit gate, channel 1 |
| bg_gate0 | input | 1 | Guard transmit gate, channel 0 |
| pin_o | output | 3 | Pin output values |
| pin_oe | output | 3 | Pin output enables, 1 = driven |

## Verification
Several rules are checked by the assertions on every cycle: the released port before configuration, the frozen configuration, the open-drain pins never driving high, the released and push-pull enables, and the rule that tick and wrap pulses only follow an accepted tick. Only the bench scenarios can show that the source mapping is right: which signal lands on which pin, the swap, the clock on pin 0, and that the wrap comes after exactly 2^16 ticks. These depend on values, not on relations between signals.

// File: rtl/stp_pkg.sv
package stp_pkg;
   localparam int NPIN = 3;

   typedef enum logic [1:0] {
      SRC_PROTO = 2'b00,
      SRC_TIME  = 2'b01,
      SRC_GUARD = 2'b10,
      SRC_OFF   = 2'b11
   } src_grp_e;

   typedef struct packed {
      src_grp_e [NPIN-1:0] grp;
      logic     [NPIN-1:0] od;
      logic                swap;
   } stp_cfg_t;
endpackage

// File: rtl/stp_timebase.sv
module stp_timebase #(
   parameter int CNT_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   output logic tick,
   output logic ovf
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] count;

   if (CNT_W < 2) begin : g_bad_width
      $error("stp_timebase: CNT_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         tick  <= 1'b0;
         ovf   <= 1'b0;
      end else begin
         tick <= tick_en;
         ovf  <= tick_en && (count == CNT_MAX);
         if (tick_en) count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/stp_cfg_latch.sv
module stp_cfg_latch
   import stp_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     init_stb,
   input  stp_cfg_t cfg_in,
   output stp_cfg_t cfg,
   output logic     cfg_vld
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg     <= '0;
         cfg_vld <= 1'b0;
      end else if (init_stb && !cfg_vld) begin
         cfg     <= cfg_in;
         cfg_vld <= 1'b1;
      end
   end
endmodule

// File: rtl/stp_pin_drive.sv
module stp_pin_drive
   import stp_pkg::*;
(
   input  logic     cfg_vld,
   input  src_grp_e grp,
   input  logic     od,
   input  logic     src_proto,
   input  logic     src_time,
   input  logic     src_guard,
   output logic     o,
   output logic     oe
);
   logic sel;
   logic off;

   always_comb begin
      unique case (grp)
         SRC_PROTO: sel = src_proto;
         SRC_TIME:  sel = src_time;
         SRC_GUARD: sel = src_guard;
         default:   sel = 1'b0;
      endcase
      off = !cfg_vld || (grp == SRC_OFF);
      if (off) begin
         o  = 1'b0;
         oe = 1'b0;
      end else if (od) begin
         o  = 1'b0;
         oe = !sel;
      end else begin
         o  = sel;
         oe = 1'b1;
      end
   end
endmodule

// File: rtl/status_port_top.sv
module status_port_top
   import stp_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       init_stb,
   input  logic [5:0] cfg_mode,
   input  logic [2:0] cfg_od,
   input  logic       cfg_swap,
   input  logic       st_vote,
   input  logic       st_sync_ok,
   input  logic       st_active,
   input  logic       bg_act,
   input  logic       bg_gate1,
   input  logic       bg_gate0,
   output logic [2:0] pin_o,
   output logic [2:0] pin_oe
);
   localparam int MODE_W = 2 * NPIN;

   if (MODE_W != 6) begin : g_bad_npin
      $error("status_port_top: pin count must be 3");
   end

   stp_cfg_t         cfg_in;
   stp_cfg_t         cfg;
   logic             cfg_vld;
   logic             tm_tick;
   logic             tm_ovf;
   logic [NPIN-1:0]  s_proto;
   logic [NPIN-1:0]  s_time;
   logic [NPIN-1:0]  s_guard;

   always_comb begin
      for (int i = 0; i < NPIN; i++) begin
         cfg_in.grp[i] = src_grp_e'(cfg_mode[2*i +: 2]);
      end
      cfg_in.od   = cfg_od;
      cfg_in.swap = cfg_swap;
   end

   stp_cfg_latch u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .init_stb (init_stb),
      .cfg_in   (cfg_in),
      .cfg      (cfg),
      .cfg_vld  (cfg_vld)
   );

   stp_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .tick    (tm_tick),
      .ovf     (tm_ovf)
   );

   // protocol sources, with optional exchange of the outer pins
   assign s_proto[2] = cfg.swap ? st_active : st_vote;
   assign s_proto[1] = st_sync_ok;
   assign s_proto[0] = cfg.swap ? st_vote : st_active;

   assign s_time  = {tm_ovf, tm_tick, clk};
   assign s_guard = {bg_act, bg_gate1, bg_gate0};

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      stp_pin_drive u_drv (
         .cfg_vld   (cfg_vld),
         .grp       (cfg.grp[p]),
         .od        (cfg.od[p]),
         .src_proto (s_proto[p]),
         .src_time  (s_time[p]),
         .src_guard (s_guard[p]),
         .o         (pin_o[p]),
         .oe        (pin_oe[p])
      );
   end
endmodule

// File: rtl/stp_checker.sv
module stp_checker
   import stp_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       tick_en,
   input logic [2:0] pin_o,
   input logic [2:0] pin_oe,
   input stp_cfg_t   cfg,
   input logic       cfg_vld,
   input logic       tm_tick,
   input logic       tm_ovf
);
   assert_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_vld |-> (pin_oe == 3'b000));

   assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_vld |=> (cfg_vld && $stable(cfg)));

   assert_tick_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tm_tick |-> $past(tick_en));

   assert_wrap_with_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tm_ovf |-> tm_tick);

   assert_od_never_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_vld |-> ((pin_o & cfg.od) == 3'b000));

   for (genvar p = 0; p < NPIN; p++) begin : g_pin_chk
      assert_off_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_vld && cfg.grp[p] == SRC_OFF) |-> (!pin_oe[p] && !pin_o[p]));

      assert_pp_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_vld && !cfg.od[p] && cfg.grp[p] != SRC_OFF) |-> pin_oe[p]);
   end
endmodule

bind status_port_top stp_checker u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick_en (tick_en),
   .pin_o   (pin_o),
   .pin_oe  (pin_oe),
   .cfg     (cfg),
   .cfg_vld (cfg_vld),
   .tm_tick (tm_tick),
   .tm_ovf  (tm_ovf)
);

// File: tb/sim_status_port_top.sv
`timescale 1ns/1ps
module sim_status_port_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       init_stb = 1'b0;
   logic [5:0] cfg_mode = '0;
   logic [2:0] cfg_od = '0;
   logic       cfg_swap = 1'b0;
   logic       st_vote = 1'b0, st_sync_ok = 1'b0, st_active = 1'b0;
   logic       bg_act = 1'b0, bg_gate1 = 1'b0, bg_gate0 = 1'b0;
   logic [2:0] pin_o, pin_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   status_port_top u0 (.*);

   // {mode[5:0], od[2:0], swap, src{vote,sync,act,bgact,g1,g0}, exp_o[2:0], exp_oe[2:0]}
   localparam int NV = 11;
   localparam logic [21:0] VEC [NV] = '{
      22'b000000_000_0_101000_101_111,  // R4 R10 protocol push-pull
      22'b000000_000_1_110000_011_111,  // R5 swap
      22'b000000_111_0_011000_000_100,  // R11 open-drain
      22'b101010_000_0_111101_101_111,  // R9 guard
      22'b101010_010_0_000010_000_101,  // R11 R12 guard, pin1 open-drain
      22'b111111_000_0_111111_000_000,  // R3 all released
      22'b100001_000_1_110011_010_111,  // R12 mixed groups
      22'b001011_001_1_001001_100_110,  // R3 R5 R12 mixed with released pin
      22'b010101_000_0_111111_000_111,  // R6 R7 R8 timing idle, clk low
      22'b000000_101_1_100000_000_110,  // R5 R11 swap with open-drain
      22'b101010_000_1_100001_001_111   // R5 swap ignored in guard mode
   };

   task automatic check(input bit ok, input string req,
                        input logic [5:0] act, input logic [5:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; init_stb = 1'b0; tick_en = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic do_init(input logic [5:0] m, input logic [2:0] od, input logic sw);
      cfg_mode = m; cfg_od = od; cfg_swap = sw; init_stb = 1'b1;
      @(negedge clk);
      init_stb = 1'b0;
   endtask

   task automatic set_src(input logic [5:0] s);
      {st_vote, st_sync_ok, st_active, bg_act, bg_gate1, bg_gate0} = s;
   endtask

   initial begin
      // R1: released from reset, with inputs active and no strobe
      do_reset();
      set_src(6'b111111); cfg_mode = 6'b000000; tick_en = 1'b1;
      repeat (3) @(negedge clk);
      check({pin_o, pin_oe} == 6'b0, "R1", {pin_o, pin_oe}, 6'b0);
      tick_en = 1'b0;

      // vector table
      for (int v = 0; v < NV; v++) begin
         do_reset();
         set_src(VEC[v][11:6]);
         @(negedge clk);
         check(pin_oe == 3'b000, "R1", {3'b0, pin_oe}, 6'b0);
         do_init(VEC[v][21:16], VEC[v][15:13], VEC[v][12]);
         check({pin_o, pin_oe} == VEC[v][5:0], $sformatf("vector %0d", v),
               {pin_o, pin_oe}, VEC[v][5:0]);
      end

      // R2: a second strobe is ignored
      do_reset();
      set_src(6'b101000);
      do_init(6'b000000, 3'b000, 1'b0);
      do_init(6'b111111, 3'b111, 1'b1);
      @(negedge clk);
      check({pin_o, pin_oe} == 6'b101_111, "R2", {pin_o, pin_oe}, 6'b101_111);

      // R6 and R8: timing mode, all push-pull
      do_reset();
      do_init(6'b010101, 3'b000, 1'b0);
      check(pin_o[1] == 1'b0, "R6 idle", {5'b0, pin_o[1]}, 6'b0);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      check(pin_o[2:1] == 2'b01, "R6 pulse", {4'b0, pin_o[2:1]}, 6'b1);
      @(negedge clk);
      check(pin_o[1] == 1'b0, "R6 single cycle", {5'b0, pin_o[1]}, 6'b0);
      @(posedge clk); #1;
      check(pin_o[0] == 1'b1, "R8 clk high", {5'b0, pin_o[0]}, 6'b1);
      @(negedge clk);
      check(pin_o[0] == 1'b0, "R8 clk low", {5'b0, pin_o[0]}, 6'b0);

      // R7: wrap after 2^16 ticks
      do_reset();
      do_init(6'b010101, 3'b000, 1'b0);
      tick_en = 1'b1;
      begin
         int early = 0;
         for (int i = 1; i <= 65536; i++) begin
            @(negedge clk);
            if (i < 65536 && pin_o[2]) early++;
         end
         check(early == 0, "R7 no early wrap", 6'(early), 6'b0);
         check(pin_o[2] == 1'b1, "R7 wrap", {5'b0, pin_o[2]}, 6'b1);
      end
      tick_en = 1'b0;
      @(negedge clk);
      check(pin_o[2] == 1'b0, "R7 wrap single cycle", {5'b0, pin_o[2]}, 6'b0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule